// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver with Frame Check

This block receives a bit-serial stream of bit-oriented frames. Clock recovery and line decoding happen upstream: the block sees one sampled data bit for each pulse of a bit-clock enable. It hunts for the flag delimiter, removes the zeros the transmitter inserted after runs of five ones, and assembles the remaining bits into characters, least significant bit first. The characters of each frame leave on a byte stream, one pulse per character. The two frame-check characters are delivered as ordinary data.

At each closing flag the block raises an end-of-frame pulse. It carries a frame-check error flag, a short-frame flag, the number of leftover bits that did not fill a whole character, and those leftover bits right-justified. The block also tells apart two line events. A run of seven ones that ends a frame already under way is reported as an abort. A run of seven ones straight after a flag is reported as an end-of-poll signal. An optional station filter compares the first character of each frame with a programmed address and drops frames that do not match.

Top module: `hdlc_frame_rx`

## Requirements
- R1: The delimiter is the bit sequence 0,1,1,1,1,1,1,0 on the line (value 0x7E). Until the first delimiter is seen the receiver produces nothing. Two delimiters with no bits between them, or with only a run of ones that is not a delimiter, produce no output.
- R2: Inside a frame, a 0 that arrives directly after five consecutive 1s is deleted. It never reaches the character data or the frame check.
- R3: Accepted bits are packed least significant bit first into 8-bit characters, and every full character is presented on `out_data` with a one-cycle `out_valid`. Delivery lags the line by six accepted bits, so a character is delivered when six further data bits have been accepted after its last bit. Delimiter bits never reach the data path.
- R4: The frame check uses x^16+x^12+x^5+1 on a 16-bit register preset to 0xFFFF at each delimiter. The register is fed with each accepted bit in line order, shifting toward the top bit. The frame is good when the register equals 0x1D0F at the closing delimiter. `crc_err` is set in the end-of-frame pulse otherwise.
- R5: A frame with at least one but fewer than 16 accepted bits ends with `short_err`=1 and `crc_err`=0.
- R6: At the end-of-frame pulse, `residue` gives the accepted bit count modulo 8. `out_data` holds those leftover bits right-justified in arrival order (bit 0 is the earliest), or 0 when `residue` is 0.
- R7: Seven consecutive 1s within a frame that has received a 0 since its opening delimiter pulse `abort_det`. The frame then ends without an end-of-frame pulse. Characters not yet delivered are dropped, and the receiver hunts for the next delimiter.
- R8: Seven consecutive 1s directly after a delimiter, with no 0 between them, pulse `eop_det` instead of `abort_det`. The receiver then hunts for the next delimiter.
- R9: With `addr_match_en`=1, a frame whose first character differs from `station_addr` produces no character pulses and no end-of-frame pulse. A matching frame is delivered in full.
- R10: All outputs are 0 after reset. Each output pulse lasts one clock cycle, follows a clock edge at which `bit_en` was 1, and at most one of `out_valid`, `frame_done`, `abort_det`, `eop_det` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One cycle per received line bit |
| rx_bit | input | 1 | Sampled line bit, valid with `bit_en` |
| addr_match_en | input | 1 | Enables the station filter on the first character |
| station_addr | input | 8 | Address compared with the first character |
| out_valid | output | 1 | Pulse: `out_data` holds a received character |
| out_data | output | 8 | Character, or leftover bits during `frame_done` |
| frame_done | output | 1 | Pulse at the closing delimiter of a delivered frame |
| crc_err | output | 1 | Frame check failed (read with `frame_done`) |
| short_err | output | 1 | Frame shorter than 16 bits (read with `frame_done`) |
| residue | output | 3 | Leftover bit count (read with `frame_done`) |
| abort_det | output | 1 | Pulse: frame aborted by a run of seven ones |
| eop_det | output | 1 | Pulse: end-of-poll run seen after a delimiter |

## Verification
Every result is registered once, on the clock edge that accepts its deciding line bit. A character is due on the edge of the sixth data bit after its last bit. The end-of-frame pulse is due on the edge of the closing delimiter's final 0. The abort or end-of-poll pulse is due on the edge of the seventh 1. The bench drives each bit for one cycle and samples outputs on the following falling edge. Its scoreboard pops an expected item for every pulse. One falling edge after the last bit of each scenario, it requires the expected queue to be empty, so a late pulse is a failure and not a deferred match. Scenarios with no expected output require the pulse count to stay unchanged.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int unsigned STUFF_ONES = 5;
    localparam int unsigned FLAG_ONES  = 6;
    localparam int unsigned ABORT_ONES = 7;
    localparam int unsigned FCS_BITS   = 16;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD = 16'h1D0F;

    typedef struct packed {
        logic dv;
        logic dbit;
        logic zero;
        logic flag;
        logic run7;
    } line_ev_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_line_decoder.sv
module hdlc_line_decoder
    import hdlc_rx_pkg::*;
#(
    parameter int RUN_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     rx_bit,
    output line_ev_t ev
);
    localparam logic [RUN_W-1:0] L_STUFF = RUN_W'(STUFF_ONES);
    localparam logic [RUN_W-1:0] L_FLAG  = RUN_W'(FLAG_ONES);
    localparam logic [RUN_W-1:0] L_SAT   = RUN_W'(ABORT_ONES);

    logic [RUN_W-1:0] ones_q;

    always_comb begin
        ev = '0;
        if (bit_en) begin
            ev.dbit = rx_bit;
            if (rx_bit) begin
                ev.dv   = (ones_q < L_STUFF);
                ev.run7 = (ones_q == L_FLAG);
            end else begin
                ev.zero = 1'b1;
                if (ones_q == L_FLAG) begin
                    ev.flag = 1'b1;
                end else if (ones_q < L_STUFF) begin
                    ev.dv = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (bit_en) begin
            if (!rx_bit)
                ones_q <= '0;
            else if (ones_q != L_SAT)
                ones_q <= ones_q + 1'b1;
        end
    end

    // R2: a stuffed zero (after five ones) must clear the run without producing data
    assert_destuff_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !rx_bit && ones_q == L_STUFF) |=> (ones_q == '0));

    assert_run_bound_R7: assert property (@(posedge clk) disable iff (rst)
        ones_q <= L_SAT);

endmodule

// File: rtl/hdlc_bit_delay.sv
module hdlc_bit_delay #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic push,
    input  logic din,
    output logic pop,
    output logic dout
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [DEPTH-1:0] sh_q;
    logic [CW-1:0]    cnt_q;

    assign pop  = push && (cnt_q == FULL);
    assign dout = sh_q[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (push) begin
            sh_q <= {sh_q[DEPTH-2:0], din};
            if (cnt_q != FULL)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the holdback never grows past its depth and stays full once popping
    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    assert_pop_full_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr) |=> (cnt_q == FULL));

endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16
    import hdlc_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= CRC_INIT;
        else if (en)
            crc <= crc_step(crc, din);
    end

    assert_crc_preset_R4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc == CRC_INIT));

    assert_crc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(crc));

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
    import hdlc_rx_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int RES_W  = $clog2(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              addr_match_en,
    input  logic [CHAR_W-1:0] station_addr,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              frame_done,
    output logic              crc_err,
    output logic              short_err,
    output logic [RES_W-1:0]  residue,
    output logic              abort_det,
    output logic              eop_det
);
    localparam int NB_W = $clog2(FCS_BITS + 1);
    localparam int SH_W = RES_W + 1;
    localparam logic [NB_W-1:0]  NB_FULL  = NB_W'(FCS_BITS);
    localparam logic [RES_W-1:0] MOD_LAST = RES_W'(CHAR_W - 1);

    line_ev_t ev;
    logic pop, dout;
    logic [15:0] crc;

    logic              in_frame_q, discard_q, first_q, seen_zero_q;
    logic [CHAR_W-1:0] sr_q;
    logic [RES_W-1:0]  mod_q;
    logic [NB_W-1:0]   nbits_q;

    hdlc_line_decoder #(.RUN_W(4)) u_dec (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .ev(ev)
    );

    hdlc_bit_delay #(.DEPTH(FLAG_ONES)) u_dly (
        .clk(clk), .rst(rst), .clr(ev.flag),
        .push(ev.dv && in_frame_q), .din(ev.dbit),
        .pop(pop), .dout(dout)
    );

    hdlc_crc16 u_crc (
        .clk(clk), .rst(rst), .clr(ev.flag), .en(pop), .din(dout), .crc(crc)
    );

    logic [CHAR_W-1:0] sr_nx, part;
    logic [SH_W-1:0]   shamt;
    logic              byte_done, long_enough;

    always_comb begin
        sr_nx       = {dout, sr_q[CHAR_W-1:1]};
        byte_done   = pop && (mod_q == MOD_LAST);
        shamt       = SH_W'(CHAR_W) - {1'b0, mod_q};
        part        = (mod_q == '0) ? '0 : (sr_q >> shamt);
        long_enough = (nbits_q == NB_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q  <= 1'b0;
            discard_q   <= 1'b0;
            first_q     <= 1'b0;
            seen_zero_q <= 1'b0;
            sr_q        <= '0;
            mod_q       <= '0;
            nbits_q     <= '0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            frame_done  <= 1'b0;
            crc_err     <= 1'b0;
            short_err   <= 1'b0;
            residue     <= '0;
            abort_det   <= 1'b0;
            eop_det     <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
            frame_done <= 1'b0;
            abort_det  <= 1'b0;
            eop_det    <= 1'b0;
            if (ev.flag) begin
                if (in_frame_q && !discard_q && nbits_q != '0) begin
                    frame_done <= 1'b1;
                    short_err  <= !long_enough;
                    crc_err    <= long_enough && (crc != CRC_GOOD);
                    residue    <= mod_q;
                    out_data   <= part;
                end
                in_frame_q  <= 1'b1;
                discard_q   <= 1'b0;
                first_q     <= 1'b1;
                seen_zero_q <= 1'b0;
                sr_q        <= '0;
                mod_q       <= '0;
                nbits_q     <= '0;
            end else if (ev.run7 && in_frame_q) begin
                if (seen_zero_q)
                    abort_det <= 1'b1;
                else
                    eop_det <= 1'b1;
                in_frame_q <= 1'b0;
            end else begin
                if (ev.zero)
                    seen_zero_q <= 1'b1;
                if (pop) begin
                    sr_q  <= sr_nx;
                    mod_q <= (mod_q == MOD_LAST) ? '0 : mod_q + 1'b1;
                    if (nbits_q != NB_FULL)
                        nbits_q <= nbits_q + 1'b1;
                    if (byte_done) begin
                        first_q <= 1'b0;
                        if (first_q && addr_match_en && sr_nx != station_addr) begin
                            discard_q <= 1'b1;
                        end else if (!discard_q) begin
                            out_valid <= 1'b1;
                            out_data  <= sr_nx;
                        end
                    end
                end
            end
        end
    end

    assert_single_event_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, frame_done, abort_det, eop_det}));

    assert_event_on_bit_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid || frame_done || abort_det || eop_det) |-> $past(bit_en));

    assert_short_no_crc_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_done && short_err) |-> !crc_err);

    assert_no_residue_data_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_done && residue == '0) |-> (out_data == '0));

endmodule

// File: tb/hdlc_frame_rx_test.sv
module hdlc_frame_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic       addr_match_en = 1'b0;
    logic [7:0] station_addr = 8'h00;
    logic       out_valid, frame_done, crc_err, short_err, abort_det, eop_det;
    logic [7:0] out_data;
    logic [2:0] residue;

    hdlc_frame_rx uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .addr_match_en(addr_match_en), .station_addr(station_addr),
        .out_valid(out_valid), .out_data(out_data), .frame_done(frame_done),
        .crc_err(crc_err), .short_err(short_err), .residue(residue),
        .abort_det(abort_det), .eop_det(eop_det)
    );

    always #10 clk = ~clk;

    localparam int K_BYTE = 0, K_DONE = 1, K_ABORT = 2, K_EOP = 3;

    typedef struct {
        int         kind;
        logic [7:0] data;
        logic       crc_e;
        logic       sh_e;
        logic [2:0] res;
        string      req;
    } item_t;

    item_t exp_q[$];
    bit    fbits[$];
    int    tests = 0, fails = 0, ev_count = 0;
    string cur_req = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int    k;
        item_t e;
        if (!rst && (out_valid || frame_done || abort_det || eop_det)) begin
            ev_count++;
            k = out_valid ? K_BYTE : frame_done ? K_DONE : abort_det ? K_ABORT : K_EOP;
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected output kind", k, -1);
            end else begin
                e = exp_q.pop_front();
                check(k == e.kind, e.req, "output kind", k, e.kind);
                if (k == e.kind && k == K_BYTE)
                    check(out_data == e.data, e.req, "character", out_data, e.data);
                if (k == e.kind && k == K_DONE) begin
                    check(crc_err == e.crc_e, e.req, "crc_err", crc_err, e.crc_e);
                    check(short_err == e.sh_e, e.req, "short_err", short_err, e.sh_e);
                    check(residue == e.res, e.req, "residue", residue, e.res);
                    check(out_data == e.data, e.req, "leftover bits", out_data, e.data);
                end
            end
        end
    end

    function automatic item_t mk(input int kind, input logic [7:0] d, input logic ce,
                                 input logic se, input logic [2:0] r, input string req);
        item_t it;
        it.kind = kind; it.data = d; it.crc_e = ce; it.sh_e = se; it.res = r; it.req = req;
        return it;
    endfunction

    function automatic logic [15:0] fcs_reg(input bit q[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (q[i]) begin
            logic fb = c[15] ^ q[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic send_bit(input bit b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
    endtask

    task automatic add_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) fbits.push_back(b[i]);
    endtask

    task automatic settle(input string req);
        @(negedge clk);
        check(exp_q.size() == 0, req, "expected outputs still outstanding", exp_q.size(), 0);
    endtask

    // builds the expected items from the bit list, then sends it stuffed and delimited
    task automatic frame(input bit open, input bit add_fcs, input bit good,
                         input bit deliver, input string req_b, input string req_d);
        bit all[$];
        int n, res, ones;
        logic [7:0] d;
        logic [15:0] c;
        all = fbits;
        if (add_fcs) begin
            c = fcs_reg(fbits);
            for (int i = 0; i < 16; i++) all.push_back(~c[15-i]);
            if (!good) all[all.size()-1] = ~all[all.size()-1];
        end
        n = all.size();
        if (deliver) begin
            for (int g = 0; g + 8 <= n; g += 8) begin
                for (int j = 0; j < 8; j++) d[j] = all[g+j];
                exp_q.push_back(mk(K_BYTE, d, 1'b0, 1'b0, 3'd0, req_b));
            end
            res = n % 8;
            d = 8'h00;
            for (int j = 0; j < res; j++) d[j] = all[n-res+j];
            exp_q.push_back(mk(K_DONE, d, (n >= 16) && !good, n < 16, 3'(res), req_d));
        end
        if (open) send_flag();
        ones = 0;
        foreach (all[i]) begin
            send_bit(all[i]);
            ones = all[i] ? ones + 1 : 0;
            if (ones == 5) begin
                send_bit(1'b0);
                ones = 0;
            end
        end
        send_flag();
        fbits.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({out_valid, frame_done, abort_det, eop_det, crc_err, short_err} == 6'b0,
              "R10", "pulse and flag outputs after reset",
              {out_valid, frame_done, abort_det, eop_det, crc_err, short_err}, 0);
        check(out_data == 8'h00 && residue == 3'd0, "R10", "data and residue after reset",
              {out_data, residue}, 0);

        // R1: hunting on idle ones, then back-to-back delimiters
        cur_req = "R1";
        base = ev_count;
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        send_flag(); send_flag(); send_flag();
        settle("R1");
        check(ev_count == base, "R1", "pulses from empty delimiters", ev_count - base, 0);

        // R2, R3, R4: stuffing-heavy good frame, its closing delimiter opens a bad one
        cur_req = "R2";
        add_byte(8'h12); add_byte(8'h34); add_byte(8'hFF); add_byte(8'h7E); add_byte(8'h1F);
        frame(1'b1, 1'b1, 1'b1, 1'b1, "R2", "R4");
        cur_req = "R4";
        add_byte(8'hA5); add_byte(8'h5A); add_byte(8'hC3);
        frame(1'b0, 1'b1, 1'b0, 1'b1, "R3", "R4");
        settle("R4");

        // R3: another good frame with a different character pattern
        cur_req = "R3";
        add_byte(8'h01); add_byte(8'h80); add_byte(8'hF8);
        frame(1'b1, 1'b1, 1'b1, 1'b1, "R3", "R4");
        settle("R3");

        // R5: a single character without check field
        cur_req = "R5";
        add_byte(8'h81);
        frame(1'b1, 1'b0, 1'b1, 1'b1, "R5", "R5");
        settle("R5");

        // R6: two characters plus three extra bits, then the check field
        cur_req = "R6";
        add_byte(8'h3C); add_byte(8'h0F);
        fbits.push_back(1'b1); fbits.push_back(1'b0); fbits.push_back(1'b1);
        frame(1'b1, 1'b1, 1'b1, 1'b1, "R6", "R6");
        settle("R6");

        // R7: abort after three characters; the third is still held back
        cur_req = "R7";
        exp_q.push_back(mk(K_BYTE, 8'h01, 1'b0, 1'b0, 3'd0, "R7"));
        exp_q.push_back(mk(K_BYTE, 8'h02, 1'b0, 1'b0, 3'd0, "R7"));
        exp_q.push_back(mk(K_ABORT, 8'h00, 1'b0, 1'b0, 3'd0, "R7"));
        send_flag();
        for (int i = 0; i < 8; i++) send_bit(1'(8'h01 >> i));
        for (int i = 0; i < 8; i++) send_bit(1'(8'h02 >> i));
        for (int i = 0; i < 8; i++) send_bit(1'(8'h03 >> i));
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        settle("R7");

        // R8: seven ones straight after a delimiter
        cur_req = "R8";
        exp_q.push_back(mk(K_EOP, 8'h00, 1'b0, 1'b0, 3'd0, "R8"));
        send_flag();
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        settle("R8");
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        settle("R8");

        // R9: station filter, matching then non-matching first character
        cur_req = "R9";
        addr_match_en = 1'b1;
        station_addr  = 8'h5A;
        add_byte(8'h5A); add_byte(8'h11); add_byte(8'h22);
        frame(1'b1, 1'b1, 1'b1, 1'b1, "R9", "R9");
        settle("R9");
        base = ev_count;
        add_byte(8'h33); add_byte(8'h44); add_byte(8'h55);
        frame(1'b1, 1'b1, 1'b1, 1'b0, "R9", "R9");
        settle("R9");
        check(ev_count == base, "R9", "pulses from filtered frame", ev_count - base, 0);
        addr_match_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule